// File: doc/BRIEF.md
# Video Black-Level Clamp Controller

This block is the digital decision path of a DC-restoration loop for up to three video channels. Each clock it takes one sample code per channel, a horizontal gate input and a two-bit clamp mode. While the gate is high it sums, per channel, the signed difference between the incoming code and that channel's clamp target. When the gate falls it takes the sign of each sum. For the rest of the low phase it then asks the analog side to sink current (level too high) or to source current (level too low).

Channel 0 carries luma (or one colour primary) and the other channels carry chroma. The mode input selects the clamp targets. It distinguishes a colour-primary setting, in which all channels clamp near black, from two colour-difference settings, in which chroma clamps to mid-scale and luma clamps to a low or a raised level. Each line's decision depends only on the samples taken during that line's gate-high time.

Top module: `blc_ctrl`

## Requirements
- R1: After reset, `sink_o` and `source_o` stay all zero until the first clock edge at which a falling gate is seen.
- R2: For every clock edge at which `hz_i` is high, the channel's accumulator adds (code − target). Samples taken while `hz_i` is low are not accumulated.
- R3: At the first clock edge with `hz_i` low after a high phase, the design sets `sink_o[c]` if the sum for channel c is positive and sets `source_o[c]` if the sum is negative. The requests are visible after that edge.
- R4: If a channel's sum is exactly zero at the decision, neither of its requests is set.
- R5: The requests hold their values at every edge while `hz_i` stays low, even when codes or mode change. They clear at the first edge at which `hz_i` is sampled high again.
- R6: The accumulator restarts at the first high sample of each gate pulse, so a decision never includes samples from an earlier line.
- R7: `mode_i` = 2'b00 (and the unused code 2'b11) sets every channel's target to 1/16 of full scale, which is code 16 for 8-bit codes.
- R8: `mode_i` = 2'b01 sets channel 0 to code 16 and all other channels to half scale (code 128).
- R9: `mode_i` = 2'b10 sets channel 0 to one quarter of full scale (code 64) and all other channels to code 128.
- R10: The accumulator saturates at its signed limits (±2^(ACC_W−1), upper limit minus one), so a very long gate never flips the sign.
- R11: For each channel, `sink_o` and `source_o` are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hz_i | input | 1 | Horizontal clamp gate, already cleaned of noise |
| mode_i | input | 2 | Clamp target select: 00 primaries, 01 colour-difference low luma, 10 colour-difference raised luma, 11 as 00 |
| code_i | input | NCH*CODE_W | Sample codes; channel c at bits [c*CODE_W +: CODE_W] |
| sink_o | output | NCH | Per-channel request to pull the input level down |
| source_o | output | NCH | Per-channel request to pull the input level up |

## Verification
The main sweep runs short constant-level lines for every code value under all four mode codes, with each channel at a different level. This exposes any wrong target, because the sink/source/idle boundary must fall exactly at each channel's target. Split lines that sit above and then below the target by equal amounts sum to zero and separate the idle case from a sign decided only by the last sample. A strong line followed by a weak line of the opposite sign shows whether the accumulator restarts. Very long lines at the extremes tell saturation apart from wraparound. Long low phases with changing codes and mode show that the requests are held and that low-phase samples are ignored.

// File: rtl/blc_pkg.sv
package blc_pkg;

  typedef enum logic [1:0] {
    CLAMP_PRIMARY  = 2'd0,
    CLAMP_CD_LOW   = 2'd1,
    CLAMP_CD_RAISE = 2'd2
  } clamp_mode_e;

  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_SINK   = 2'd1,
    DEC_SOURCE = 2'd2
  } clamp_dec_e;

  // Unused select code falls back to the primaries setting.
  function automatic clamp_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'b01:   return CLAMP_CD_LOW;
      2'b10:   return CLAMP_CD_RAISE;
      default: return CLAMP_PRIMARY;
    endcase
  endfunction

  // Targets as fractions of full scale: 1/16, 1/4 or 1/2.
  function automatic int unsigned target_code(input clamp_mode_e m,
                                              input int unsigned ch,
                                              input int unsigned code_w);
    int unsigned sixteenth;
    int unsigned quarter;
    int unsigned half;
    sixteenth = 32'd1 << (code_w - 4);
    quarter   = 32'd1 << (code_w - 2);
    half      = 32'd1 << (code_w - 1);
    if (m == CLAMP_PRIMARY) return sixteenth;
    if (ch != 0) return half;
    return (m == CLAMP_CD_RAISE) ? quarter : sixteenth;
  endfunction

endpackage

// File: rtl/blc_hz_edge.sv
module blc_hz_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hz_i,
  output logic rise_o,
  output logic fall_o
);
  logic hz_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hz_q <= 1'b0;
    else        hz_q <= hz_i;
  end

  assign rise_o = hz_i & ~hz_q;
  assign fall_o = ~hz_i & hz_q;
endmodule

// File: rtl/blc_channel.sv
module blc_channel
  import blc_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hz_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] tgt_i,
  output logic              sink_o,
  output logic              source_o,
  output logic              acc_pos_o,
  output logic              acc_neg_o
);
  localparam int EXT_W = ACC_W - CODE_W;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [CODE_W:0]  diff_w;
  logic signed [ACC_W-1:0] acc_q;
  clamp_dec_e              dec_q;

  // Sum of accumulator and sign-extended difference, clipped to the limits.
  function automatic logic signed [ACC_W-1:0] sat_add(
      input logic signed [ACC_W-1:0] a,
      input logic signed [CODE_W:0]  d);
    logic signed [ACC_W:0] s;
    s = $signed({a[ACC_W-1], a}) + $signed({{EXT_W{d[CODE_W]}}, d});
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? ACC_MIN : ACC_MAX;
    return s[ACC_W-1:0];
  endfunction

  assign diff_w = $signed({1'b0, code_i}) - $signed({1'b0, tgt_i});

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (rise_i) acc_q <= sat_add('0, diff_w);
    else if (hz_i)   acc_q <= sat_add(acc_q, diff_w);
  end

  assign acc_neg_o = acc_q[ACC_W-1];
  assign acc_pos_o = !acc_q[ACC_W-1] && (acc_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      dec_q <= DEC_IDLE;
    else if (rise_i) dec_q <= DEC_IDLE;
    else if (fall_i) dec_q <= acc_pos_o ? DEC_SINK :
                              (acc_neg_o ? DEC_SOURCE : DEC_IDLE);
  end

  assign sink_o   = (dec_q == DEC_SINK);
  assign source_o = (dec_q == DEC_SOURCE);
endmodule

// File: rtl/blc_ctrl.sv
module blc_ctrl
  import blc_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CODE_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hz_i,
  input  logic [1:0]            mode_i,
  input  logic [NCH*CODE_W-1:0] code_i,
  output logic [NCH-1:0]        sink_o,
  output logic [NCH-1:0]        source_o
);
  logic           rise_w;
  logic           fall_w;
  logic [NCH-1:0] acc_pos_w;
  logic [NCH-1:0] acc_neg_w;
  clamp_mode_e    mode_w;

  assign mode_w = decode_mode(mode_i);

  blc_hz_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .hz_i   (hz_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CODE_W-1:0] tgt_w;
    assign tgt_w = CODE_W'(target_code(mode_w, g, CODE_W));

    blc_channel #(.CODE_W(CODE_W), .ACC_W(ACC_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .hz_i      (hz_i),
      .rise_i    (rise_w),
      .fall_i    (fall_w),
      .code_i    (code_i[g*CODE_W +: CODE_W]),
      .tgt_i     (tgt_w),
      .sink_o    (sink_o[g]),
      .source_o  (source_o[g]),
      .acc_pos_o (acc_pos_w[g]),
      .acc_neg_o (acc_neg_w[g])
    );
  end
endmodule

// File: rtl/blc_ctrl_chk.sv
module blc_ctrl_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rise_w,
  input logic           fall_w,
  input logic [NCH-1:0] acc_pos_w,
  input logic [NCH-1:0] acc_neg_w,
  input logic [NCH-1:0] sink_o,
  input logic [NCH-1:0] source_o
);
  logic seen_fall_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      seen_fall_q <= 1'b0;
    else if (fall_w) seen_fall_q <= 1'b1;
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_fall_q |-> (sink_o == '0 && source_o == '0));

  assert_decide_by_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> (sink_o == $past(acc_pos_w) && source_o == $past(acc_neg_w)));

  assert_zero_stays_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> ((sink_o | source_o) == $past(acc_pos_w | acc_neg_w)));

  assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_w && !rise_w) |=> ($stable(sink_o) && $stable(source_o)));

  assert_clear_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> (sink_o == '0 && source_o == '0));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_o & source_o) == '0);
endmodule

bind blc_ctrl blc_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rise_w    (rise_w),
  .fall_w    (fall_w),
  .acc_pos_w (acc_pos_w),
  .acc_neg_w (acc_neg_w),
  .sink_o    (sink_o),
  .source_o  (source_o)
);

// File: tb/blc_ctrl_test.sv
`timescale 1ns/1ps
module blc_ctrl_test;
  localparam int NCH    = 3;
  localparam int CODE_W = 8;
  localparam int ACC_W  = 20;
  localparam longint LIM_HI = (64'sd1 <<< (ACC_W - 1)) - 1;
  localparam longint LIM_LO = -(64'sd1 <<< (ACC_W - 1));

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  hz = 1'b0;
  logic [1:0]            mode = 2'b00;
  logic [NCH*CODE_W-1:0] codes = '0;
  logic [NCH-1:0]        sink;
  logic [NCH-1:0]        source;

  int total = 0;
  int bad = 0;
  logic [NCH-1:0] last_sink = '0;
  logic [NCH-1:0] last_src  = '0;

  always #2 clk = ~clk;

  blc_ctrl #(.NCH(NCH), .CODE_W(CODE_W), .ACC_W(ACC_W)) uut (
    .clk(clk), .rst_n(rst_n), .hz_i(hz), .mode_i(mode),
    .code_i(codes), .sink_o(sink), .source_o(source)
  );

  function automatic int exp_target(input logic [1:0] m, input int ch);
    if (m == 2'b01) return (ch == 0) ? 16 : 128;
    if (m == 2'b10) return (ch == 0) ? 64 : 128;
    return 16;
  endfunction

  task automatic check(input string tag, input logic [NCH-1:0] es,
                       input logic [NCH-1:0] eo);
    total++;
    if (sink !== es || source !== eo) begin
      bad++;
      $display("FAIL %s: sink=%b source=%b expected sink=%b source=%b",
               tag, sink, source, es, eo);
    end
  endtask

  // One gate pulse of n samples: the first split samples use a*, the rest b*.
  task automatic run_line(input logic [1:0] m, input int n, input int split,
                          input int a0, input int a1, input int a2,
                          input int b0, input int b1, input int b2,
                          input string tag);
    longint s [NCH];
    int c [NCH];
    for (int k = 0; k < NCH; k++) s[k] = 0;
    mode = m;
    for (int i = 0; i < n; i++) begin
      if (i < split) begin c[0] = a0; c[1] = a1; c[2] = a2; end
      else           begin c[0] = b0; c[1] = b1; c[2] = b2; end
      for (int k = 0; k < NCH; k++) begin
        codes[k*CODE_W +: CODE_W] = CODE_W'(c[k]);
        s[k] = s[k] + c[k] - exp_target(m, k);
        if (s[k] > LIM_HI) s[k] = LIM_HI;
        if (s[k] < LIM_LO) s[k] = LIM_LO;
      end
      hz = 1'b1;
      @(negedge clk);
    end
    hz = 1'b0;
    codes = {CODE_W'(b2 ^ 8'h5a), CODE_W'(b1 ^ 8'ha5), CODE_W'(b0 ^ 8'hff)};
    @(negedge clk);
    for (int k = 0; k < NCH; k++) begin
      last_sink[k] = (s[k] > 0);
      last_src[k]  = (s[k] < 0);
    end
    check(tag, last_sink, last_src);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0, '0);
    codes = {8'd255, 8'd0, 8'd255};
    hz = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 high phase before first fall", '0, '0);
    hz = 1'b0;
    @(negedge clk);
    repeat (2) @(negedge clk);

    // Exhaustive level sweep over every mode code and code value.
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 256; v++) begin
        string tg;
        tg = (m == 1) ? "R8 R2 R3 R4" : (m == 2) ? "R9 R2 R3 R4" : "R7 R2 R3 R4";
        run_line(2'(m), 3, 3, v, 255 - v, (v * 7) & 255, 0, 0, 0, tg);
      end
    end

    // Equal excursions above and below the target cancel.
    run_line(2'b00, 10, 5, 21, 11, 200, 11, 21, 0, "R4 split 00");
    run_line(2'b10, 8, 4, 70, 120, 128, 58, 136, 128, "R4 split 10");
    run_line(2'b01, 9, 1, 24, 128, 100, 15, 128, 131, "R3 late sign");

    // Hold through a long low phase while codes and mode change.
    run_line(2'b01, 4, 4, 200, 20, 128, 0, 0, 0, "R3 before hold");
    for (int i = 0; i < 6; i++) begin
      mode = 2'(i);
      codes = {8'(i * 40), 8'(255 - i * 30), 8'(i * 11)};
      @(negedge clk);
      check("R5 hold in low phase", last_sink, last_src);
    end
    hz = 1'b1;
    mode = 2'b00;
    codes = {8'd16, 8'd16, 8'd16};
    @(negedge clk);
    check("R5 clear on rise", '0, '0);
    hz = 1'b0;
    repeat (3) @(negedge clk);

    // A new line ignores the previous line's sum.
    run_line(2'b00, 20, 20, 255, 0, 255, 0, 0, 0, "R6 strong line");
    run_line(2'b00, 2, 2, 15, 17, 16, 0, 0, 0, "R6 restart");

    // Long lines at the extremes: saturation keeps the sign.
    run_line(2'b00, 2300, 2300, 255, 0, 16, 0, 0, 0, "R10 positive limit");
    run_line(2'b01, 4200, 4200, 0, 0, 255, 0, 0, 0, "R10 negative limit");

    // Exclusion over a mixed batch.
    for (int v = 0; v < 16; v++) begin
      run_line(2'b10, 2, 1, v * 16, 255 - v * 16, v * 9, v, 128, 64, "R11 mixed");
      total++;
      if ((sink & source) != '0) begin
        bad++;
        $display("FAIL R11: sink=%b source=%b expected disjoint", sink, source);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule